// File: doc/BRIEF.md
# Latched Alarm Status and Interrupt Register

This block sits beside a T3/E3 framer and turns its live alarm conditions into a status word that software can read. Seven conditions arrive as synchronous levels, one per clock: loss of signal, loss of frame, alarm indication signal, remote alarm, idle, and the transmit and receive start-of-frame markers. The block compares each one with its value in the previous cycle. A condition that is active, or that has just changed in either direction, sets a sticky status bit. Reading the status word clears every bit whose condition has gone away. A bit whose condition is still present stays at one.

Each change of state also leaves an interrupt event pending. The single interrupt output is asserted only when three things hold together: a pending event, the matching bit of a per-alarm mask register, and a global enable bit. A read of the status word clears all pending events. A simple synchronous bus gives access to the registers. Read data appears one cycle after the read and holds until the next read.

Top module: `alarm_stat_irq`

## Requirements
- R1: The status word sits at address 0x12. Bit 0 is loss of signal, bit 1 loss of frame, bit 2 alarm indication, bit 3 remote alarm, bit 4 idle, bit 5 transmit start-of-frame and bit 6 receive start-of-frame. Bits 15..7 read as zero.
- R2: A condition input that is high at a clock edge leaves its status bit at one after that edge. This holds even across a status read.
- R3: A change of state of a condition, rising or falling, sets its status bit. The bit stays set after the condition returns to its old level.
- R4: A read (en=1, wr=0) of 0x12 places the current status on the read data in the next cycle. It clears every status bit whose condition is low and whose condition did not change in that cycle.
- R5: A change of state in the same cycle as a status read wins. The status bit stays set and its interrupt event stays pending.
- R6: A write to 0x12 leaves the status word and the pending events unchanged.
- R7: The mask register at 0x13 stores bits 6..0 (same bit order as R1), and its upper bits read as zero. The global enable is bit 0 of 0x14, and its other bits read as zero. Both can be written and read back.
- R8: The interrupt output is high exactly one cycle after a cycle in which the global enable is set and at least one pending event has its mask bit set.
- R9: A status read clears all pending events. With no new change of state, the interrupt output is low two cycles after the read.
- R10: After reset, the status, pending events, mask, enable, read data and interrupt output are all zero.
- R11: Reads of any address other than 0x12, 0x13 and 0x14 return zero. Writes to such addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cond_i | input | 7 | Live alarm condition levels, bit order as in R1 |
| bus_en_i | input | 1 | Bus access strobe |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 8 | Register address |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data, valid the cycle after a read, held until the next read |
| irq_o | output | 1 | Active-high registered interrupt |

## Verification
A stale copy of the previous condition levels shows up as a wrong or missing status bit on the very next read. It also shows up as an interrupt that rises two cycles after an edge that never happened, or as an expected interrupt that never rises. If the pending events were not cleared, the interrupt would stay high past the second cycle after a read. If a status bit were cleared while its condition was still active, the next read would show zero for an alarm that is still live. The reference model compares the read data and the interrupt after every clock edge, so any of these faults appears within one to two cycles of the stimulus that exposes it.

// File: rtl/alarm_stat_pkg.sv
package alarm_stat_pkg;

    localparam int ALM_W  = 7;
    localparam int BUS_AW = 8;
    localparam int BUS_DW = 16;

    typedef struct packed {
        logic rd_stat;
        logic wr_stat;
        logic rd_mask;
        logic wr_mask;
        logic rd_gen;
        logic wr_gen;
    } bus_dec_t;

endpackage

// File: rtl/alarm_chg_det.sv
module alarm_chg_det #(
    parameter int N = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] cond_i,
    output logic [N-1:0] chg_o
);

    typedef struct packed {
        logic [N-1:0] prev;
    } chg_state_t;

    chg_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = cond_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign chg_o = cond_i ^ st_q.prev;

    // A change seen now means the level differs from the one latched one edge ago
    assert_chg_vs_past_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (chg_o == (cond_i ^ $past(cond_i))));

endmodule

// File: rtl/alarm_status_bank.sv
module alarm_status_bank #(
    parameter int N = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] cond_i,
    input  logic [N-1:0] chg_i,
    input  logic         rd_clr_i,
    output logic [N-1:0] status_o,
    output logic [N-1:0] pend_o
);

    typedef struct packed {
        logic [N-1:0] stat;
        logic [N-1:0] pend;
    } bank_state_t;

    bank_state_t  st_d, st_q;
    logic [N-1:0] stat_nx;
    logic [N-1:0] pend_nx;

    for (genvar g = 0; g < N; g++) begin : g_bit
        // live level or a fresh change keeps the bit; otherwise a read drops it
        assign stat_nx[g] = cond_i[g] | chg_i[g] | (st_q.stat[g] & ~rd_clr_i);
        // events survive until a status read, a new change always wins
        assign pend_nx[g] = chg_i[g] | (st_q.pend[g] & ~rd_clr_i);
    end

    always_comb begin
        st_d      = st_q;
        st_d.stat = stat_nx;
        st_d.pend = pend_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign status_o = st_q.stat;
    assign pend_o   = st_q.pend;

    assert_active_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (|cond_i) |=> ((status_o & $past(cond_i)) == $past(cond_i)));

    assert_change_latches_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (|chg_i) |=> ((status_o & $past(chg_i)) == $past(chg_i)));

    assert_read_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr_i && !(|chg_i) && !(|cond_i)) |=> (status_o == '0));

    assert_event_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr_i && (|chg_i)) |=> ((pend_o & $past(chg_i)) == $past(chg_i)));

    assert_pend_cleared_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr_i && !(|chg_i)) |=> (pend_o == '0));

endmodule

// File: rtl/alarm_cfg_regs.sv
module alarm_cfg_regs #(
    parameter int N  = 7,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_mask_i,
    input  logic          wr_gen_i,
    input  logic [DW-1:0] wdata_i,
    output logic [N-1:0]  mask_o,
    output logic          gen_o
);

    typedef struct packed {
        logic [N-1:0] mask;
        logic         gen;
    } cfg_state_t;

    cfg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_mask_i) begin
            st_d.mask = wdata_i[N-1:0];
        end
        if (wr_gen_i) begin
            st_d.gen = wdata_i[0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mask_o = st_q.mask;
    assign gen_o  = st_q.gen;

    assert_cfg_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_mask_i && !wr_gen_i) |=> ($stable(mask_o) && $stable(gen_o)));

endmodule

// File: rtl/alarm_irq_gate.sv
module alarm_irq_gate #(
    parameter int N = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pend_i,
    input  logic [N-1:0] mask_i,
    input  logic         gen_i,
    output logic         irq_o
);

    typedef struct packed {
        logic irq;
    } irq_state_t;

    irq_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.irq = gen_i & (|(pend_i & mask_i));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_o = st_q.irq;

    assert_irq_has_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ($past(gen_i) && ($past(pend_i) != '0)));

    assert_irq_off_gen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !gen_i |=> !irq_o);

endmodule

// File: rtl/alarm_stat_irq.sv
module alarm_stat_irq
    import alarm_stat_pkg::*;
#(
    parameter int          NUM_ALM   = ALM_W,
    parameter int          AW        = BUS_AW,
    parameter int          DW        = BUS_DW,
    parameter logic [7:0]  STAT_ADDR = 8'h12,
    parameter logic [7:0]  MASK_ADDR = 8'h13,
    parameter logic [7:0]  GEN_ADDR  = 8'h14
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_ALM-1:0]  cond_i,
    input  logic                bus_en_i,
    input  logic                bus_wr_i,
    input  logic [AW-1:0]       bus_addr_i,
    input  logic [DW-1:0]       bus_wdata_i,
    output logic [DW-1:0]       bus_rdata_o,
    output logic                irq_o
);

    localparam int PAD_W = DW - NUM_ALM;

    typedef struct packed {
        logic [DW-1:0] rdata;
    } top_state_t;

    top_state_t         st_d, st_q;
    bus_dec_t           dec;
    logic [NUM_ALM-1:0] chg;
    logic [NUM_ALM-1:0] status;
    logic [NUM_ALM-1:0] pend;
    logic [NUM_ALM-1:0] mask;
    logic               gen;

    always_comb begin
        dec         = '0;
        dec.rd_stat = bus_en_i && !bus_wr_i && (bus_addr_i == AW'(STAT_ADDR));
        dec.wr_stat = bus_en_i &&  bus_wr_i && (bus_addr_i == AW'(STAT_ADDR));
        dec.rd_mask = bus_en_i && !bus_wr_i && (bus_addr_i == AW'(MASK_ADDR));
        dec.wr_mask = bus_en_i &&  bus_wr_i && (bus_addr_i == AW'(MASK_ADDR));
        dec.rd_gen  = bus_en_i && !bus_wr_i && (bus_addr_i == AW'(GEN_ADDR));
        dec.wr_gen  = bus_en_i &&  bus_wr_i && (bus_addr_i == AW'(GEN_ADDR));
    end

    alarm_chg_det #(.N(NUM_ALM)) u_chg (
        .clk    (clk),
        .rst_n  (rst_n),
        .cond_i (cond_i),
        .chg_o  (chg)
    );

    alarm_status_bank #(.N(NUM_ALM)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .cond_i   (cond_i),
        .chg_i    (chg),
        .rd_clr_i (dec.rd_stat),
        .status_o (status),
        .pend_o   (pend)
    );

    alarm_cfg_regs #(.N(NUM_ALM), .DW(DW)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_mask_i (dec.wr_mask),
        .wr_gen_i  (dec.wr_gen),
        .wdata_i   (bus_wdata_i),
        .mask_o    (mask),
        .gen_o     (gen)
    );

    alarm_irq_gate #(.N(NUM_ALM)) u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .pend_i (pend),
        .mask_i (mask),
        .gen_i  (gen),
        .irq_o  (irq_o)
    );

    always_comb begin
        st_d = st_q;
        if (bus_en_i && !bus_wr_i) begin
            st_d.rdata = '0;
            if (dec.rd_stat) begin
                st_d.rdata = {{PAD_W{1'b0}}, status};
            end else if (dec.rd_mask) begin
                st_d.rdata = {{PAD_W{1'b0}}, mask};
            end else if (dec.rd_gen) begin
                st_d.rdata = {{(DW-1){1'b0}}, gen};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_rdata_o = st_q.rdata;

    assert_stat_write_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (dec.wr_stat && !(|chg) && !(|cond_i)) |=> ($stable(status) && $stable(pend)));

    assert_upper_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(dec.rd_stat) |-> (bus_rdata_o[DW-1:NUM_ALM] == '0));

    assert_unmapped_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en_i && !bus_wr_i && !dec.rd_stat && !dec.rd_mask && !dec.rd_gen)
        |=> (bus_rdata_o == '0));

endmodule

// File: tb/alarm_stat_irq_tb.sv
module alarm_stat_irq_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  cond_i = '0;
    logic        bus_en_i = 1'b0;
    logic        bus_wr_i = 1'b0;
    logic [7:0]  bus_addr_i = '0;
    logic [15:0] bus_wdata_i = '0;
    logic [15:0] bus_rdata_o;
    logic        irq_o;

    int    n_chk  = 0;
    int    n_fail = 0;
    string cur_req = "R10";
    bit    done = 1'b0;

    // behavioural reference state
    bit [6:0]  m_prev, m_stat, m_pend, m_mask;
    bit        m_gen, m_irq;
    bit [15:0] m_rdata;

    always #2 clk = ~clk;

    alarm_stat_irq u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cond_i      (cond_i),
        .bus_en_i    (bus_en_i),
        .bus_wr_i    (bus_wr_i),
        .bus_addr_i  (bus_addr_i),
        .bus_wdata_i (bus_wdata_i),
        .bus_rdata_o (bus_rdata_o),
        .irq_o       (irq_o)
    );

    task automatic model_step();
        bit [6:0]  n_stat, n_pend, chg;
        bit        any;
        bit        rd = bus_en_i && !bus_wr_i;
        bit        wr = bus_en_i && bus_wr_i;
        if (!rst_n) begin
            m_prev = 0; m_stat = 0; m_pend = 0; m_mask = 0;
            m_gen = 0; m_irq = 0; m_rdata = 0;
            return;
        end
        any = 0;
        for (int i = 0; i < 7; i++) if (m_pend[i] && m_mask[i]) any = 1;
        chg = cond_i ^ m_prev;
        for (int i = 0; i < 7; i++) begin
            n_stat[i] = m_stat[i];
            n_pend[i] = m_pend[i];
            if (rd && bus_addr_i == 8'h12) begin
                n_stat[i] = 0;
                n_pend[i] = 0;
            end
            if (cond_i[i] || chg[i]) n_stat[i] = 1;
            if (chg[i]) n_pend[i] = 1;
        end
        if (rd) begin
            case (bus_addr_i)
                8'h12:   m_rdata = {9'd0, m_stat};
                8'h13:   m_rdata = {9'd0, m_mask};
                8'h14:   m_rdata = {15'd0, m_gen};
                default: m_rdata = 0;
            endcase
        end
        m_irq  = m_gen && any;
        m_stat = n_stat;
        m_pend = n_pend;
        m_prev = cond_i;
        if (wr && bus_addr_i == 8'h13) m_mask = bus_wdata_i[6:0];
        if (wr && bus_addr_i == 8'h14) m_gen = bus_wdata_i[0];
    endtask

    task automatic cyc();
        @(posedge clk);
        model_step();
        #1;
        n_chk++;
        if (bus_rdata_o !== m_rdata) begin
            n_fail++;
            $display("FAIL %s rdata actual=%h expected=%h t=%0t", cur_req, bus_rdata_o, m_rdata, $time);
        end
        n_chk++;
        if (irq_o !== m_irq) begin
            n_fail++;
            $display("FAIL %s irq actual=%b expected=%b t=%0t", cur_req, irq_o, m_irq, $time);
        end
        bus_en_i = 0; bus_wr_i = 0;
    endtask

    task automatic rd(input bit [7:0] a);
        bus_en_i = 1; bus_wr_i = 0; bus_addr_i = a;
        cyc();
    endtask

    task automatic wr(input bit [7:0] a, input bit [15:0] d);
        bus_en_i = 1; bus_wr_i = 1; bus_addr_i = a; bus_wdata_i = d;
        cyc();
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) cyc();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        cur_req = "R10";
        idle(3);
        rst_n = 1;
        idle(2);
        rd(8'h12); rd(8'h13); rd(8'h14); idle(1);

        cur_req = "R11";
        rd(8'h00); rd(8'hFF); wr(8'h20, 16'hFFFF); rd(8'h13); rd(8'h14); idle(1);

        cur_req = "R7";
        wr(8'h13, 16'hFFFF); rd(8'h13); idle(1);
        wr(8'h14, 16'hFFFF); rd(8'h14); idle(1);
        wr(8'h13, 16'h0055); rd(8'h13); wr(8'h13, 16'h007F); rd(8'h13);

        cur_req = "R3";
        cond_i = 7'h01; cyc(); cond_i = 7'h00; idle(3);
        rd(8'h12); idle(2);

        cur_req = "R9";
        rd(8'h12); idle(3);

        cur_req = "R2";
        cond_i = 7'h02; idle(3);
        rd(8'h12); idle(2); rd(8'h12); idle(1);
        cond_i = 7'h00; idle(1); rd(8'h12); idle(1); rd(8'h12); idle(2);

        cur_req = "R5";
        cond_i = 7'h04; rd(8'h12); idle(2);
        rd(8'h12); idle(2);
        cond_i = 7'h00; rd(8'h12); idle(2); rd(8'h12); idle(2);

        cur_req = "R6";
        cond_i = 7'h08; cyc(); cond_i = 7'h00; idle(1);
        wr(8'h12, 16'h0000); rd(8'h12); idle(1);
        wr(8'h12, 16'hFFFF); rd(8'h12); rd(8'h12); idle(2);

        cur_req = "R8";
        wr(8'h13, 16'h0010);
        cond_i = 7'h20; cyc(); cond_i = 7'h00; idle(3);
        rd(8'h12); idle(2);
        cond_i = 7'h10; idle(3);
        wr(8'h14, 16'h0000); idle(2);
        wr(8'h14, 16'h0001); idle(2);
        wr(8'h13, 16'h0000); idle(2);
        wr(8'h13, 16'h0010); idle(2);
        cond_i = 7'h00; rd(8'h12); idle(2); rd(8'h12); idle(2);

        cur_req = "R1";
        wr(8'h13, 16'h007F);
        for (int b = 0; b < 7; b++) begin
            cond_i = 7'(1 << b); cyc(); cond_i = 0; idle(1);
            rd(8'h12); idle(1); rd(8'h12); idle(2);
        end
        cond_i = 7'h7F; idle(2); rd(8'h12); idle(1);
        cond_i = 7'h2A; idle(1); rd(8'h12); idle(1);
        cond_i = 7'h00; rd(8'h12); idle(1); rd(8'h12); idle(2);

        cur_req = "R10";
        cond_i = 7'h33; idle(1); rst_n = 0; idle(2);
        cond_i = 0; rst_n = 1; idle(1);
        rd(8'h12); rd(8'h13); rd(8'h14); idle(2);

        finish_run();
    end

endmodule